// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block runs single-word reads and writes on an external asynchronous static RAM from a synchronous clock domain. Memory timing limits are parameters in nanoseconds, chosen as a set through a speed-grade parameter (55, 70, 100 or 200 ns). The clock period is also a parameter. At elaboration the block turns every limit into a whole number of clocks and builds the cycle lengths from those numbers.

A request enters through a valid/ready handshake that carries a write flag, an address and write data. A read returns its word on `rd_data` with a one-clock `rd_valid` strobe. On the memory side the block drives the address, two chip selects of opposite polarity, write and output enables, and a split data bus with a drive-enable.

The write pulse is framed by write enable while both chip selects stay active. The chip selects remain active one clock past the rising write-enable edge. A parameter picks between two write variants. In one, output enable stays high for the whole write. In the other, output enable is held low while write enable is low; the block then waits for the memory to release the bus before it drives data.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, and from reset, chip select 1 (active low) is high, chip select 2 (active high) is low, write and output enables (active low) are high, the data drive-enable is low and `req_ready` is high.
- R2: Each nanosecond limit becomes a clock count equal to the ratio to the clock period rounded up, never less than one. At a 20 ns clock and the 55 ns grade, a read holds 3 clocks and write enable is low for 3 clocks.
- R3: A read keeps the address, both chip selects and output enable active for the read count of clocks, which is the largest of cycle time, address access, select access and output-enable access. It samples the memory data on the last of those clocks, and the returned word is the one last written to that address (0 if never written).
- R4: During a write, write enable is low for the largest of pulse width, select-to-end, address-to-end and (cycle time minus one clock) counts, and both chip selects are active whenever write enable is low.
- R5: A write ends on the rising edge of write enable. The chip selects, address and data drive stay one more clock, and the pins then return to the idle state.
- R6: With output enable held high during writes (`OE_LOW_WRITE`=0), the data bus is driven on every clock of the write-enable low pulse, 3 clocks before its rising edge at the defaults, and through the following hold clock.
- R7: With output enable held low during writes (`OE_LOW_WRITE`=1), output enable is low while write enable is low and high in the hold clock. The data bus is not driven for the bus-release count (1 at defaults) after write enable falls. Write enable stays low for at least that count plus the data-setup count, and data is driven 2 clocks before the rising edge at the defaults.
- R8: The drive-enable is never high while the memory may drive the bus (both selects active, output enable low, write enable high), and never high while the memory is deselected.
- R9: `req_ready` is low from the clock after a request is accepted until the memory cycle ends. A request is taken only while `req_ready` is high, and a new request may follow in the first idle clock.
- R10: Every read gives exactly one `rd_valid` pulse, one clock wide. A write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_out` |

## Verification
The assertions check several pin relations on every cycle. Write enable never goes low outside both chip selects. The selects and the data drive are still active at the clock where write enable rises. The pins are idle whenever ready is high. The read strobe never lasts two clocks, and each write-enable pulse reaches its minimum clock count. Other behaviour shows only in the bench's scenarios against a behavioural memory model. Those scenarios cover the data returned by reads, the exact pulse and drive lengths in each write variant, and the absence of bus contention across back-to-back mixed transfers.

// File: rtl/sram_tmg_pkg.sv
package sram_tmg_pkg;

   typedef struct packed {
      int unsigned cyc_rd;
      int unsigned acc_addr;
      int unsigned acc_sel;
      int unsigned acc_oe;
      int unsigned cyc_wr;
      int unsigned sel_to_end;
      int unsigned addr_to_end;
      int unsigned we_pulse;
      int unsigned dat_setup;
      int unsigned we_bus_off;
   } sram_tmg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_HOLD = 2'd3
   } seq_st_e;

   function automatic sram_tmg_t grade_tmg(input int unsigned grade);
      sram_tmg_t t;
      case (grade)
         70:      t = '{70, 70, 70, 35, 70, 60, 60, 55, 30, 25};
         100:     t = '{100, 100, 100, 75, 100, 100, 100, 90, 60, 50};
         200:     t = '{200, 200, 200, 125, 200, 190, 190, 125, 100, 100};
         default: t = '{55, 55, 55, 20, 55, 45, 45, 45, 25, 20};
      endcase
      return t;
   endfunction

   function automatic int unsigned ns2clk(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_tmg_pkg::*;
#(
   parameter int unsigned RD_CLKS      = 3,
   parameter int unsigned WE_CLKS      = 3,
   parameter int unsigned HZ_CLKS      = 1,
   parameter bit          OE_LOW_WRITE = 1'b0,
   parameter int unsigned CNT_W        = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic idle,
   output logic accept,
   output logic rd_done,
   output logic nxt_sel,
   output logic nxt_we,
   output logic nxt_oe,
   output logic nxt_drv
);

   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CLKS - 1);
   localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CLKS - 1);

   seq_st_e          st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      accept  = 1'b0;
      rd_done = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  st_d  = ST_WR;
                  cnt_d = WE_LOAD;
               end else begin
                  st_d  = ST_RD;
                  cnt_d = RD_LOAD;
               end
            end
         end
         ST_RD: begin
            if (cnt_q == '0) begin
               rd_done = 1'b1;
               st_d    = ST_IDLE;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WR: begin
            if (cnt_q == '0) st_d = ST_HOLD;
            else             cnt_d = cnt_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign idle    = (st_q == ST_IDLE);
   assign nxt_sel = (st_d != ST_IDLE);
   assign nxt_we  = (st_d == ST_WR);

   generate
      if (OE_LOW_WRITE) begin : g_oe_low
         logic [CNT_W-1:0] elapsed_d;
         assign elapsed_d = WE_LOAD - cnt_d;
         assign nxt_oe  = (st_d == ST_RD) || (st_d == ST_WR);
         assign nxt_drv = ((st_d == ST_WR) && (elapsed_d >= CNT_W'(HZ_CLKS)))
                          || (st_d == ST_HOLD);
      end else begin : g_oe_high
         assign nxt_oe  = (st_d == ST_RD);
         assign nxt_drv = (st_d == ST_WR) || (st_d == ST_HOLD);
      end
   endgenerate

endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              nxt_sel,
   input  logic              nxt_we,
   input  logic              nxt_oe,
   input  logic              nxt_drv,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce1_n <= 1'b1;
         mem_ce2   <= 1'b0;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_ce1_n <= ~nxt_sel;
         mem_ce2   <= nxt_sel;
         mem_we_n  <= ~nxt_we;
         mem_oe_n  <= ~nxt_oe;
         mem_dq_oe <= nxt_drv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_done;
         if (rd_done) rd_data <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_tmg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned SPEED_GRADE   = 55,
   parameter bit          OE_LOW_WRITE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam sram_tmg_t TM = grade_tmg(SPEED_GRADE);
   localparam int unsigned P = CLK_PERIOD_NS;

   localparam int unsigned RD_CLKS = umax(umax(ns2clk(TM.cyc_rd, P), ns2clk(TM.acc_addr, P)),
                                          umax(ns2clk(TM.acc_sel, P), ns2clk(TM.acc_oe, P)));
   localparam int unsigned HZ_CLKS = ns2clk(TM.we_bus_off, P);
   localparam int unsigned SD_CLKS = ns2clk(TM.dat_setup, P);
   localparam int unsigned WC_CLKS = ns2clk(TM.cyc_wr, P);
   localparam int unsigned WE_BASE = umax(umax(ns2clk(TM.we_pulse, P), ns2clk(TM.sel_to_end, P)),
                                          umax(ns2clk(TM.addr_to_end, P),
                                               (WC_CLKS > 1) ? WC_CLKS - 1 : 1));
   localparam int unsigned WE_CLKS = OE_LOW_WRITE ? umax(WE_BASE, HZ_CLKS + SD_CLKS)
                                                  : umax(WE_BASE, SD_CLKS);
   localparam int unsigned CNT_W   = $clog2(umax(RD_CLKS, WE_CLKS) + 1) + 1;

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be at least 1");
      end
      if (SPEED_GRADE != 55 && SPEED_GRADE != 70 &&
          SPEED_GRADE != 100 && SPEED_GRADE != 200) begin : g_bad_grade
         $error("SPEED_GRADE must be 55, 70, 100 or 200");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic idle, accept, rd_done;
   logic nxt_sel, nxt_we, nxt_oe, nxt_drv;

   sram_seq_fsm #(
      .RD_CLKS      (RD_CLKS),
      .WE_CLKS      (WE_CLKS),
      .HZ_CLKS      (HZ_CLKS),
      .OE_LOW_WRITE (OE_LOW_WRITE),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .idle      (idle),
      .accept    (accept),
      .rd_done   (rd_done),
      .nxt_sel   (nxt_sel),
      .nxt_we    (nxt_we),
      .nxt_oe    (nxt_oe),
      .nxt_drv   (nxt_drv)
   );

   sram_pin_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .nxt_sel    (nxt_sel),
      .nxt_we     (nxt_we),
      .nxt_oe     (nxt_oe),
      .nxt_drv    (nxt_drv),
      .mem_addr   (mem_addr),
      .mem_ce1_n  (mem_ce1_n),
      .mem_ce2    (mem_ce2),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   sram_rd_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_done   (rd_done),
      .mem_dq_in (mem_dq_in),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign req_ready = idle;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int unsigned WE_CLKS = 3
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rd_valid,
   input logic mem_ce1_n,
   input logic mem_ce2,
   input logic mem_we_n,
   input logic mem_oe_n,
   input logic mem_dq_oe
);

   logic [15:0] we_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_lo_cnt <= '0;
      else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 16'd1;
      else                we_lo_cnt <= '0;
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

   AST_WE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce1_n && mem_ce2)); // R4

   AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= 16'(WE_CLKS))); // R4

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe)); // R5

   AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_ce1_n && mem_ce2 && (mem_oe_n || !mem_we_n))); // R8

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce1_n |-> !req_ready); // R9

   AST_RDV_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.WE_CLKS(WE_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .mem_ce1_n (mem_ce1_n),
   .mem_ce2   (mem_ce2),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_bhv_model #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   input  logic          ce1_n,
   input  logic          ce2,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [DW-1:0] dq_out,
   input  logic          dq_oe,
   output logic [DW-1:0] dq_in,
   output int            we_len,
   output int            drv_len,
   output int            rd_len,
   output int            clash,
   output int            stray,
   output int            hold_ok,
   output int            wr_cnt
);
   logic [DW-1:0] mem [0:(1<<AW)-1];
   logic sel;
   int   we_run = 0, drv_run = 0, rd_run = 0;
   logic we_prev = 1'b1;

   initial begin
      for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
      we_len = 0; drv_len = 0; rd_len = 0; clash = 0; stray = 0; hold_ok = 0; wr_cnt = 0;
   end

   assign sel   = !ce1_n && ce2;
   assign dq_in = (sel && !oe_n && we_n) ? mem[addr] : '0;

   always @(posedge we_n) if (sel) mem[addr] = dq_out;

   always @(negedge clk) begin
      if (!we_n) begin
         we_run++;
         if (dq_oe) drv_run++;
      end else if (!we_prev) begin
         we_len  = we_run;
         drv_len = drv_run;
         hold_ok = (sel && dq_oe && oe_n) ? 1 : 0;
         wr_cnt++;
         we_run  = 0;
         drv_run = 0;
      end
      if (sel && !oe_n && we_n) rd_run++;
      else if (rd_run > 0) begin
         rd_len = rd_run;
         rd_run = 0;
      end
      if (dq_oe && sel && !oe_n && we_n) clash++;
      if (dq_oe && !sel) stray++;
      we_prev = we_n;
   end
endmodule

module sram_async_ctrl_tb_top;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr  = '0;
   logic [DW-1:0] req_wdata = '0;

   logic          rdy0, rdy1, rdv0, rdv1;
   logic [DW-1:0] rdd0, rdd1;
   logic [AW-1:0] ma0, ma1;
   logic          c1n0, c1n1, c20, c21, wen0, wen1, oen0, oen1, doe0, doe1;
   logic [DW-1:0] dqo0, dqo1, dqi0, dqi1;
   int we_len0, drv_len0, rd_len0, clash0, stray0, hold0, wrc0;
   int we_len1, drv_len1, rd_len1, clash1, stray1, hold1, wrc1;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(20),
                     .SPEED_GRADE(55), .OE_LOW_WRITE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rdd0), .rd_valid(rdv0), .mem_addr(ma0), .mem_ce1_n(c1n0),
      .mem_ce2(c20), .mem_we_n(wen0), .mem_oe_n(oen0), .mem_dq_out(dqo0),
      .mem_dq_in(dqi0), .mem_dq_oe(doe0));

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(20),
                     .SPEED_GRADE(55), .OE_LOW_WRITE(1'b1)) dut_oe_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rdd1), .rd_valid(rdv1), .mem_addr(ma1), .mem_ce1_n(c1n1),
      .mem_ce2(c21), .mem_we_n(wen1), .mem_oe_n(oen1), .mem_dq_out(dqo1),
      .mem_dq_in(dqi1), .mem_dq_oe(doe1));

   sram_bhv_model #(.AW(AW), .DW(DW)) mdl0 (
      .clk(clk), .addr(ma0), .ce1_n(c1n0), .ce2(c20), .we_n(wen0), .oe_n(oen0),
      .dq_out(dqo0), .dq_oe(doe0), .dq_in(dqi0), .we_len(we_len0), .drv_len(drv_len0),
      .rd_len(rd_len0), .clash(clash0), .stray(stray0), .hold_ok(hold0), .wr_cnt(wrc0));

   sram_bhv_model #(.AW(AW), .DW(DW)) mdl1 (
      .clk(clk), .addr(ma1), .ce1_n(c1n1), .ce2(c21), .we_n(wen1), .oe_n(oen1),
      .dq_out(dqo1), .dq_oe(doe1), .dq_in(dqi1), .we_len(we_len1), .drv_len(drv_len1),
      .rd_len(rd_len1), .clash(clash1), .stray(stray1), .hold_ok(hold1), .wr_cnt(wrc1));

   int n_tests = 0;
   int n_fail  = 0;
   int reads_issued = 0;
   int rdv_cnt0 = 0, rdv_cnt1 = 0;
   int rdy_mismatch = 0;
   bit finished = 1'b0;
   logic [DW-1:0] shadow [0:(1<<AW)-1];
   logic [DW-1:0] exp_q0 [$];
   logic [DW-1:0] exp_q1 [$];
   logic rdv0_prev = 1'b0, rdv1_prev = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check(c1n0 && !c20 && wen0 && oen0 && !doe0 && rdy0, {"R1 ", tag},
            {c1n0, c20, wen0, oen0, doe0, rdy0}, 6'b101101);
      check(c1n1 && !c21 && wen1 && oen1 && !doe1 && rdy1, {"R1 oe-low ", tag},
            {c1n1, c21, wen1, oen1, doe1, rdy1}, 6'b101101);
   endtask

   // Scoreboard monitor: pops expected read words as strobes appear.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rdy0 !== rdy1) rdy_mismatch++;
         if (rdv0) begin
            rdv_cnt0++;
            check(!rdv0_prev, "R10 strobe width", 2, 1);
            if (exp_q0.size() == 0) check(1'b0, "R10 unexpected strobe", 1, 0);
            else begin
               logic [DW-1:0] e;
               e = exp_q0.pop_front();
               check(rdd0 == e, "R3 read data", rdd0, e);
            end
         end
         if (rdv1) begin
            rdv_cnt1++;
            check(!rdv1_prev, "R10 strobe width oe-low", 2, 1);
            if (exp_q1.size() == 0) check(1'b0, "R10 unexpected strobe oe-low", 1, 0);
            else begin
               logic [DW-1:0] e;
               e = exp_q1.pop_front();
               check(rdd1 == e, "R3 read data oe-low", rdd1, e);
            end
         end
      end
      rdv0_prev = rdv0;
      rdv1_prev = rdv1;
   end

   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int wr0_before, wr1_before;
      wr0_before = wrc0;
      wr1_before = wrc1;
      @(negedge clk);
      while (!rdy0) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      if (!wr) begin
         exp_q0.push_back(shadow[a]);
         exp_q1.push_back(shadow[a]);
         reads_issued++;
      end else begin
         shadow[a] = d;
      end
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = ~d;
      check(!rdy0 && !rdy1, "R9 ready low after accept", rdy0, 0);
      while (!rdy0) @(negedge clk);
      #2;
      check_idle("after cycle");
      check(rdv_cnt0 == reads_issued && rdv_cnt1 == reads_issued, "R10 strobe count",
            rdv_cnt0, reads_issued);
      if (wr) begin
         check(wrc0 == wr0_before + 1 && wrc1 == wr1_before + 1, "R5 one write pulse",
               wrc0 - wr0_before, 1);
         check(we_len0 == 3, "R2 R4 we low clocks", we_len0, 3);
         check(we_len1 == 3, "R4 R7 we low clocks oe-low", we_len1, 3);
         check(drv_len0 == 3, "R6 data driven before we rise", drv_len0, 3);
         check(drv_len1 == 2, "R7 data driven after bus release", drv_len1, 2);
         check(hold0 == 1 && hold1 == 1, "R5 select and data held past we rise", hold0 + hold1, 2);
      end else begin
         check(rd_len0 == 3, "R2 R3 read active clocks", rd_len0, 3);
         check(rd_len1 == 3, "R3 read active clocks oe-low", rd_len1, 3);
      end
   endtask

   initial begin
      for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("after reset");

      issue(1'b1, 8'h05, 16'hA5A5);
      issue(1'b1, 8'h10, 16'h1234);
      issue(1'b0, 8'h05, 16'h0000);
      issue(1'b0, 8'h10, 16'h0000);
      issue(1'b0, 8'h33, 16'h0000);
      issue(1'b1, 8'hFF, 16'hFFFF);
      issue(1'b0, 8'hFF, 16'h0000);
      issue(1'b1, 8'h05, 16'h0F0F);
      issue(1'b0, 8'h05, 16'h0000);
      for (int k = 0; k < 6; k++) begin
         issue(1'b1, 8'(k * 37), 16'(k * 4099 + 7));
         issue(1'b0, 8'(k * 37), 16'h0000);
      end
      issue(1'b1, 8'h00, 16'h0000);
      issue(1'b0, 8'h00, 16'h0000);

      repeat (4) @(negedge clk);
      check(clash0 == 0 && clash1 == 0, "R8 no bus contention", clash0 + clash1, 0);
      check(stray0 == 0 && stray1 == 0, "R8 no drive while deselected", stray0 + stray1, 0);
      check(exp_q0.size() == 0 && exp_q1.size() == 0, "R10 all reads returned",
            exp_q0.size() + exp_q1.size(), 0);
      check(rdy_mismatch == 0, "R9 variants share cycle length", rdy_mismatch, 0);
      check_idle("at end");
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule